// File: doc/BRIEF.md
# Logarithmic Funnel Shifter

A purely combinational shift and rotate unit for a WIDTH-bit datapath. One operation code chooses among rotate, logical shift and arithmetic shift, each to the right or to the left. The shift distance is an unsigned amount from 0 to WIDTH-1. All six operations share a single window-select network. A front stage builds a (2*WIDTH-1)-bit source field whose content depends on the operation. A chain of log2(WIDTH) two-input multiplexer ranks then picks a WIDTH-bit window out of that field. The shift amount drives those ranks bit by bit, with no decoding step.

For a right operation, the operand sits in the low half of the field and the fill sits above it. The window offset equals the shift amount. For a left operation, the operand sits in the high half and the fill sits below it. The window offset is the bitwise inverse of the shift amount, which equals WIDTH-1-k. For this reason WIDTH must be a power of two. A small decoder turns the operation code into a control struct that the source generator and the offset logic both use.

Top module: `funnel_shifter`

## Requirements
- R1: opSel = 0 (rotate right) gives the operand rotated right by k, with bits leaving position 0 re-entering at position WIDTH-1.
- R2: opSel = 1 (logical right) gives the operand shifted right by k, with the k most significant result bits zero.
- R3: opSel = 2 (arithmetic right) gives the operand shifted right by k, with the k most significant result bits equal to operand bit WIDTH-1.
- R4: opSel = 3 (rotate left) gives the operand rotated left by k, with bits leaving position WIDTH-1 re-entering at position 0.
- R5: opSel = 4 (logical left) gives the operand shifted left by k, with the k least significant result bits zero.
- R6: opSel = 5 (arithmetic left) gives the same result as opSel = 4 for every operand and amount.
- R7: opSel = 6 and opSel = 7 return the operand unchanged, whatever the shift amount.
- R8: a shift amount of 0 returns the operand unchanged for every operation code.
- R9: for WIDTH = 4, operand 1011 and k = 1, the results are: rotate right 1101, logical right 0101, arithmetic right 1101, rotate left 0111, logical left 0110, arithmetic left 0110.
- R10: the output is a combinational function of the present inputs. It settles in the same cycle that the inputs change, and it holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | WIDTH | Operand to shift or rotate |
| shiftAmt | input | $clog2(WIDTH) | Shift distance k, 0 to WIDTH-1 |
| opSel | input | 3 | Operation code (0 ROR, 1 LSR, 2 ASR, 3 ROL, 4 LSL, 5 ASL, 6/7 pass) |
| dataOut | output | WIDTH | Shifted or rotated result |

## Verification
The hardest cases to reach are the wrap and fill bits at the far ends of the window. Examples are a rotate left by WIDTH-1, where the offset is zero and the fill supplies all but one bit, and an arithmetic right shift of a negative operand by the largest amount. These cases only show up when the operand's top and bottom bits differ from the bits around them. The stimulus therefore sweeps every operation against every amount at WIDTH = 8, using operands with a set sign bit and alternating patterns. It then repeats the sweep at WIDTH = 32 with random operands that are forced to both sign polarities.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic [2:0] {
    OP_ROR  = 3'd0,
    OP_LSR  = 3'd1,
    OP_ASR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_LSL  = 3'd4,
    OP_ASL  = 3'd5,
    OP_PAS6 = 3'd6,
    OP_PAS7 = 3'd7
  } shift_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_WRAP = 2'd1,
    FILL_SIGN = 2'd2
  } fill_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic  leftDir;    // operand goes in the high half, offset is ~k
    fill_e fillKind;   // what occupies the other half of the source field
    logic  holdOffset; // force a zero offset (pass-through)
  } funnel_ctl_t;

endpackage

// File: rtl/funnel_ctrl.sv
module funnel_ctrl
  import funnel_pkg::*;
(
  input  logic [2:0]  opSel,
  output funnel_ctl_t ctl
);

  always_comb begin
    ctl.leftDir    = 1'b0;
    ctl.fillKind   = FILL_ZERO;
    ctl.holdOffset = 1'b0;
    unique case (shift_op_e'(opSel))
      OP_ROR: ctl.fillKind = FILL_WRAP;
      OP_LSR: ctl.fillKind = FILL_ZERO;
      OP_ASR: ctl.fillKind = FILL_SIGN;
      OP_ROL: begin
        ctl.leftDir  = 1'b1;
        ctl.fillKind = FILL_WRAP;
      end
      OP_LSL, OP_ASL: begin
        ctl.leftDir  = 1'b1;
        ctl.fillKind = FILL_ZERO;
      end
      default: ctl.holdOffset = 1'b1;
    endcase
  end

endmodule

// File: rtl/funnel_src.sv
module funnel_src
  import funnel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SRCW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] dataIn,
  input  funnel_ctl_t      ctl,
  output logic [SRCW-1:0]  srcField
);

  logic [WIDTH-2:0] fillBits;

  always_comb begin
    unique case (ctl.fillKind)
      FILL_WRAP: fillBits = ctl.leftDir ? dataIn[WIDTH-1:1] : dataIn[WIDTH-2:0];
      FILL_SIGN: fillBits = {(WIDTH-1){dataIn[WIDTH-1]}};
      default:   fillBits = '0;
    endcase
  end

  assign srcField = ctl.leftDir ? {dataIn, fillBits} : {fillBits, dataIn};

endmodule

// File: rtl/funnel_mux.sv
module funnel_mux #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int SRCW = 2 * WIDTH - 1
) (
  input  logic [SRCW-1:0]  srcField,
  input  logic [SHW-1:0]   offset,
  output logic [WIDTH-1:0] window
);

  // Rank s moves the field down by 2**s when offset[s] is set; each rank
  // drops the top bits that later ranks can no longer reach.
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    localparam int INW  = 2 * WIDTH - STEP;
    localparam int OUTW = 2 * WIDTH - 2 * STEP;
    logic [INW-1:0]  stIn;
    logic [OUTW-1:0] stOut;
    if (s == 0) begin : g_first
      assign stIn = srcField;
    end else begin : g_next
      assign stIn = g_stage[s-1].stOut;
    end
    assign stOut = offset[s] ? stIn[INW-1:STEP] : stIn[OUTW-1:0];
  end

  assign window = g_stage[SHW-1].stOut;

endmodule

// File: rtl/funnel_datapath.sv
module funnel_datapath
  import funnel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH),
  localparam int SRCW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SHW-1:0]   shiftAmt,
  input  funnel_ctl_t      ctl,
  output logic [WIDTH-1:0] dataOut
);

  logic [SRCW-1:0] srcField;
  logic [SHW-1:0]  offset;

  funnel_src #(.WIDTH(WIDTH)) u_src (
    .dataIn   (dataIn),
    .ctl      (ctl),
    .srcField (srcField)
  );

  // For a power-of-two width, ~k equals WIDTH-1-k.
  always_comb begin
    if (ctl.holdOffset)   offset = '0;
    else if (ctl.leftDir) offset = ~shiftAmt;
    else                  offset = shiftAmt;
  end

  funnel_mux #(.WIDTH(WIDTH)) u_mux (
    .srcField (srcField),
    .offset   (offset),
    .window   (dataOut)
  );

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SHW-1:0]   shiftAmt,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] dataOut
);

  funnel_ctl_t ctl;

  funnel_ctrl u_ctrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  funnel_datapath #(.WIDTH(WIDTH)) u_dp (
    .dataIn   (dataIn),
    .shiftAmt (shiftAmt),
    .ctl      (ctl),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int WIDTH = 32,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] dataIn,
  input logic [SHW-1:0]   shiftAmt,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] dataOut
);

  always_comb begin
    // R7
    if (opSel >= 3'd6) passthru_chk: assert (dataOut == dataIn);
    // R8
    if (shiftAmt == '0) zero_amt_chk: assert (dataOut == dataIn);
    // R1 R4
    if (opSel == 3'd0 || opSel == 3'd3)
      rot_weight_chk: assert ($countones(dataOut) == $countones(dataIn));
    // R3
    if (opSel == 3'd2) asr_sign_chk: assert (dataOut[WIDTH-1] == dataIn[WIDTH-1]);
    // R2
    if (opSel == 3'd1 && shiftAmt != '0) lsr_msb_chk: assert (dataOut[WIDTH-1] == 1'b0);
    // R5 R6
    if ((opSel == 3'd4 || opSel == 3'd5) && shiftAmt != '0)
      lsl_lsb_chk: assert (dataOut[0] == 1'b0);
  end

endmodule

bind funnel_shifter funnel_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .dataIn   (dataIn),
  .shiftAmt (shiftAmt),
  .opSel    (opSel),
  .dataOut  (dataOut)
);

// File: tb/tb_funnel_shifter.sv
module tb_funnel_shifter;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int nCompared = 0;
  int nMismatched = 0;
  bit finished = 1'b0;

  logic [31:0] a32;  logic [4:0] k32;  logic [2:0] op32;  logic [31:0] y32;
  logic [7:0]  a8;   logic [2:0] k8;   logic [2:0] op8;   logic [7:0]  y8;
  logic [3:0]  a4;   logic [1:0] k4;   logic [2:0] op4;   logic [3:0]  y4;

  funnel_shifter #(.WIDTH(32)) dut  (.dataIn(a32), .shiftAmt(k32), .opSel(op32), .dataOut(y32));
  funnel_shifter #(.WIDTH(8))  dut8 (.dataIn(a8),  .shiftAmt(k8),  .opSel(op8),  .dataOut(y8));
  funnel_shifter #(.WIDTH(4))  dut4 (.dataIn(a4),  .shiftAmt(k4),  .opSel(op4),  .dataOut(y4));

  string reqOf [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R7"};

  // Behavioural model for an n-bit operand held in the low bits
  function automatic logic [31:0] refModel(input logic [31:0] a, input int k,
                                           input int op, input int n);
    logic [63:0] m, x, r;
    m = (64'd1 << n) - 64'd1;
    x = {32'd0, a} & m;
    case (op)
      0: r = (x >> k) | (x << (n - k));
      1: r = x >> k;
      2: r = (x >> k) | (x[n-1] ? (m & ~(m >> k)) : 64'd0);
      3: r = (x << k) | (x >> (n - k));
      4, 5: r = x << k;
      default: r = x;
    endcase
    r = r & m;
    return r[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    nCompared++;
    if (got !== exp) begin
      nMismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // R10: outputs follow inputs within the same cycle, no clock involved
  task automatic testIdle();
    @(negedge clk);
    a32 = '0; k32 = '0; op32 = 3'd0;
    a8 = '0; k8 = '0; op8 = 3'd0;
    a4 = '0; k4 = '0; op4 = 3'd0;
    #1;
    check("R10", y32, 32'd0, "zero inputs width32");
    a32 = 32'hDEAD_BEEF; k32 = 5'd4; op32 = 3'd1;
    #1;
    check("R10", y32, 32'h0DEA_DBEE, "same-cycle response");
  endtask

  // R9: four-bit example values
  task automatic testExample4();
    logic [3:0] expv [6] = '{4'b1101, 4'b0101, 4'b1101, 4'b0111, 4'b0110, 4'b0110};
    for (int op = 0; op < 6; op++) begin
      @(negedge clk);
      a4 = 4'b1011; k4 = 2'd1; op4 = op[2:0];
      #2;
      check("R9", {28'd0, y4}, {28'd0, expv[op]}, $sformatf("width4 op%0d", op));
    end
  endtask

  // R1..R6, R8: every operation and every amount at width 8
  task automatic testSweep8();
    logic [7:0] pats [4] = '{8'hB5, 8'h81, 8'h7E, 8'hC3};
    for (int p = 0; p < 4; p++)
      for (int op = 0; op < 6; op++)
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          a8 = pats[p]; k8 = k[2:0]; op8 = op[2:0];
          #2;
          check(k == 0 ? "R8" : reqOf[op], {24'd0, y8},
                refModel({24'd0, pats[p]}, k, op, 8),
                $sformatf("width8 a=%h op%0d k%0d", pats[p], op, k));
        end
  endtask

  // R1..R6: random operands at width 32, both sign polarities
  task automatic testRandom32();
    for (int r = 0; r < 4; r++)
      for (int op = 0; op < 6; op++)
        for (int k = 0; k < 32; k++) begin
          logic [31:0] v;
          v = $urandom;
          v[31] = r[0];
          @(negedge clk);
          a32 = v; k32 = k[4:0]; op32 = op[2:0];
          #2;
          check(reqOf[op], y32, refModel(v, k, op, 32),
                $sformatf("width32 a=%h op%0d k%0d", v, op, k));
        end
  endtask

  // R6: arithmetic left equals logical left
  task automatic testAslEqualsLsl();
    for (int k = 0; k < 32; k++) begin
      logic [31:0] lsl;
      @(negedge clk);
      a32 = 32'h8000_0001 ^ (32'h1 << k); k32 = k[4:0]; op32 = 3'd4;
      #2;
      lsl = y32;
      op32 = 3'd5;
      #2;
      check("R6", y32, lsl, $sformatf("ASL vs LSL k%0d", k));
    end
  endtask

  // R7: reserved codes pass the operand for any amount
  task automatic testPassThrough();
    for (int code = 6; code < 8; code++)
      for (int k = 0; k < 32; k += 7) begin
        @(negedge clk);
        a32 = 32'hA5C3_0F96; k32 = k[4:0]; op32 = code[2:0];
        #2;
        check("R7", y32, 32'hA5C3_0F96, $sformatf("code%0d k%0d", code, k));
      end
  endtask

  // R8: zero amount is identity for all codes
  task automatic testZeroAmount();
    for (int op = 0; op < 8; op++) begin
      @(negedge clk);
      a32 = 32'hF00D_1234; k32 = '0; op32 = op[2:0];
      #2;
      check("R8", y32, 32'hF00D_1234, $sformatf("op%0d k0", op));
    end
  endtask

  initial begin
    testIdle();
    testExample4();
    testSweep8();
    testRandom32();
    testAslEqualsLsl();
    testPassThrough();
    testZeroAmount();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

endmodule